// File: doc/BRIEF.md
# Transmit Buffer Bid Controller

This block runs the host side of a transmit handshake for a frame controller. Before sending any payload, the host bids for buffer space. It does this by writing a frame length to a dedicated word port. The block checks the length. An illegal length raises a bid-error status and reserves nothing. A legal length is turned into the number of 16-bit words it needs. The block then watches the free-space count reported by buffer management until that many words are available.

Once space is available, the block raises a ready status that the host can poll. It also latches a sticky space-available event, which can drive an interrupt request when the host has enabled it. While ready, each host write to the data port is passed on as a payload write strobe. The block counts these writes until the bid is filled, then drops back to idle. Writing a new length at any time discards the bid in progress and starts a new evaluation. A separate command port latches a transmit command word for the downstream logic.

Top module: `tx_bid_ctrl`

## Requirements
- R1: After synchronous reset, `rdy_now`, `bid_err`, `evt_rdy`, `irq`, `pay_we` and `pay_last` are 0, and `cmd_word` is 0.
- R2: A write to byte offset 6 (length port) with a value of 0 or greater than 1514 sets `bid_err` on the next clock edge. No ready status follows, whatever the free space is.
- R3: A write of a legal length (1 to 1514) clears `bid_err`. After that, `rdy_now` rises on the clock edge following the first edge at which `free_words` is at least ceil(length/2). While `free_words` is below that, `rdy_now` stays 0.
- R4: `evt_rdy` sets on the same edge as `rdy_now` rises. `irq` equals `evt_rdy` AND `rdy_irq_en`.
- R5: A one-cycle pulse on `evt_read` clears `evt_rdy`, and with it `irq`, on the next edge. `rdy_now` is left unchanged.
- R6: While `rdy_now` is 1, each write to byte offset 0 (data port) drives `pay_we` in that same cycle, with `pay_data` equal to the written word. `pay_last` is 1 on write number ceil(length/2). After that write, `rdy_now` is 0.
- R7: Data-port writes while `rdy_now` is 0 produce no `pay_we`.
- R8: A length write while a bid is waiting or ready abandons that bid. On the next edge, `rdy_now` and `evt_rdy` are 0 and the word count restarts for the new length.
- R9: A write to byte offset 4 (command port) is held on `cmd_word` from the next edge onward.
- R10: Odd lengths round up to whole words: length 1 takes 1 word, 61 takes 31, and 1514 takes 757. Length 1515 is a bid error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host write strobe, one word per cycle |
| host_addr | input | ADDR_W (4) | Byte offset of the target port |
| host_wdata | input | DATA_W (16) | Host write data |
| evt_read | input | 1 | Host read of the event register; clears the event |
| rdy_irq_en | input | 1 | Interrupt enable for the space-available event |
| free_words | input | FREE_W (11) | Free buffer space in words |
| rdy_now | output | 1 | Ready-for-transmit status |
| bid_err | output | 1 | Last length written was illegal |
| evt_rdy | output | 1 | Sticky space-available event |
| irq | output | 1 | Interrupt request |
| cmd_word | output | DATA_W (16) | Latched transmit command |
| pay_we | output | 1 | Payload word write strobe |
| pay_data | output | DATA_W (16) | Payload word |
| pay_last | output | 1 | Marks the final payload word of the bid |

## Verification
The bench drives the length boundaries 0, 1, 1514, 1515 and 0xFFFF, plus odd lengths. A checker with an off-by-one range test would accept 1515 or refuse 1514. Wrong rounding would end the payload one word early or late, which shows up in `pay_last` and in when `rdy_now` falls. The bench also holds free space one word short of the request, to catch a comparison that grants too early. It abandons a bid halfway through its payload, to catch a word counter that does not restart. It clears the event while ready, to catch a read that also drops `rdy_now`.

// File: rtl/tx_bid_pkg.sv
package tx_bid_pkg;

    typedef enum logic [1:0] {
        BID_IDLE  = 2'd0,
        BID_WAIT  = 2'd1,
        BID_READY = 2'd2
    } bid_state_e;

    // byte offsets of the host word ports
    localparam int unsigned OFS_DATA = 0;
    localparam int unsigned OFS_CMD  = 4;
    localparam int unsigned OFS_LEN  = 6;

    // words needed to carry n bytes
    function automatic int unsigned bytes_to_words(input int unsigned n);
        return (n + 1) / 2;
    endfunction

endpackage

// File: rtl/tx_bid_eval.sv
module tx_bid_eval #(
    parameter int LEN_W   = 16,
    parameter int MAX_LEN = 1514,
    parameter int WORD_W  = 10
) (
    input  logic [LEN_W-1:0]  len,
    output logic              len_ok,
    output logic [WORD_W-1:0] len_words
);
    logic [LEN_W:0] rounded;

    always_comb begin
        len_ok    = (len != '0) && ({1'b0, len} <= (LEN_W+1)'(MAX_LEN));
        rounded   = ({1'b0, len} + (LEN_W+1)'(1)) >> 1;
        len_words = len_ok ? WORD_W'(rounded) : '0;
    end
endmodule

// File: rtl/tx_word_counter.sv
module tx_word_counter #(
    parameter int WORD_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WORD_W-1:0] need_in,
    input  logic              step,
    output logic [WORD_W-1:0] need,
    output logic              at_last
);
    logic [WORD_W-1:0] need_q;
    logic [WORD_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            need_q <= '0;
            cnt_q  <= '0;
        end else if (load) begin
            need_q <= need_in;
            cnt_q  <= '0;
        end else if (step) begin
            cnt_q  <= cnt_q + WORD_W'(1);
        end
    end

    assign need    = need_q;
    assign at_last = (cnt_q == need_q - WORD_W'(1));
endmodule

// File: rtl/tx_bid_ctrl.sv
module tx_bid_ctrl #(
    parameter int DATA_W  = 16,
    parameter int LEN_W   = 16,
    parameter int MAX_LEN = 1514,
    parameter int FREE_W  = 11,
    parameter int ADDR_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              evt_read,
    input  logic              rdy_irq_en,
    input  logic [FREE_W-1:0] free_words,
    output logic              rdy_now,
    output logic              bid_err,
    output logic              evt_rdy,
    output logic              irq,
    output logic [DATA_W-1:0] cmd_word,
    output logic              pay_we,
    output logic [DATA_W-1:0] pay_data,
    output logic              pay_last
);
    import tx_bid_pkg::*;

    localparam int MAX_WORDS = bytes_to_words(MAX_LEN);
    localparam int WORD_W    = $clog2(MAX_WORDS + 1);

    bid_state_e        state_q;
    logic              wr_len, wr_cmd, wr_dat;
    logic              len_ok;
    logic [WORD_W-1:0] len_words;
    logic [WORD_W-1:0] need;
    logic              at_last;
    logic              space_ok;
    logic              grant;
    logic              err_q, evt_q;
    logic [DATA_W-1:0] cmd_q;

    assign wr_len = host_we && (host_addr == ADDR_W'(OFS_LEN));
    assign wr_cmd = host_we && (host_addr == ADDR_W'(OFS_CMD));
    assign wr_dat = host_we && (host_addr == ADDR_W'(OFS_DATA));

    tx_bid_eval #(
        .LEN_W  (LEN_W),
        .MAX_LEN(MAX_LEN),
        .WORD_W (WORD_W)
    ) u_eval (
        .len      (LEN_W'(host_wdata)),
        .len_ok   (len_ok),
        .len_words(len_words)
    );

    tx_word_counter #(
        .WORD_W(WORD_W)
    ) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .load   (wr_len && len_ok),
        .need_in(len_words),
        .step   (pay_we),
        .need   (need),
        .at_last(at_last)
    );

    assign space_ok = ({{(FREE_W+1){1'b0}}, need} <= {{(WORD_W+1){1'b0}}, free_words});
    assign grant    = (state_q == BID_WAIT) && space_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= BID_IDLE;
            err_q   <= 1'b0;
        end else if (wr_len) begin
            state_q <= len_ok ? BID_WAIT : BID_IDLE;
            err_q   <= !len_ok;
        end else begin
            case (state_q)
                BID_WAIT:  if (space_ok) state_q <= BID_READY;
                BID_READY: if (pay_we && at_last) state_q <= BID_IDLE;
                default:   state_q <= BID_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)           evt_q <= 1'b0;
        else if (wr_len)   evt_q <= 1'b0;
        else if (grant)    evt_q <= 1'b1;
        else if (evt_read) evt_q <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)         cmd_q <= '0;
        else if (wr_cmd) cmd_q <= host_wdata;
    end

    assign rdy_now  = (state_q == BID_READY);
    assign bid_err  = err_q;
    assign evt_rdy  = evt_q;
    assign irq      = evt_q && rdy_irq_en;
    assign cmd_word = cmd_q;
    assign pay_we   = wr_dat && rdy_now;
    assign pay_data = host_wdata;
    assign pay_last = pay_we && at_last;
endmodule

// File: rtl/tx_bid_ctrl_chk.sv
module tx_bid_ctrl_chk #(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              host_we,
    input logic [ADDR_W-1:0] host_addr,
    input logic              evt_read,
    input logic              rdy_irq_en,
    input logic              rdy_now,
    input logic              bid_err,
    input logic              evt_rdy,
    input logic              irq,
    input logic              pay_we,
    input logic              pay_last
);
    logic len_wr;
    assign len_wr = host_we && (host_addr == ADDR_W'(tx_bid_pkg::OFS_LEN));

    AST_ERR_NO_READY: assert property (@(posedge clk) disable iff (rst)
        bid_err |-> !rdy_now);                                              // R2
    AST_READY_SETS_EVT: assert property (@(posedge clk) disable iff (rst)
        $rose(rdy_now) |-> evt_rdy);                                        // R4
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
        irq |-> (evt_rdy && rdy_irq_en));                                   // R4
    AST_EVT_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (evt_read && !len_wr) |=> (!evt_rdy || $rose(rdy_now)));            // R5
    AST_LAST_ENDS_BID: assert property (@(posedge clk) disable iff (rst)
        (pay_we && pay_last) |=> !rdy_now);                                 // R6
    AST_PAY_ONLY_READY: assert property (@(posedge clk) disable iff (rst)
        pay_we |-> rdy_now);                                                // R7
    AST_LEN_ABANDONS: assert property (@(posedge clk) disable iff (rst)
        len_wr |=> (!rdy_now && !evt_rdy));                                 // R8
endmodule

bind tx_bid_ctrl tx_bid_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .host_we   (host_we),
    .host_addr (host_addr),
    .evt_read  (evt_read),
    .rdy_irq_en(rdy_irq_en),
    .rdy_now   (rdy_now),
    .bid_err   (bid_err),
    .evt_rdy   (evt_rdy),
    .irq       (irq),
    .pay_we    (pay_we),
    .pay_last  (pay_last)
);

// File: tb/tx_bid_ctrl_test.sv
module tx_bid_ctrl_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_we = 1'b0;
    logic [3:0]  host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic        evt_read = 1'b0;
    logic        rdy_irq_en = 1'b0;
    logic [10:0] free_words = '0;
    logic        rdy_now, bid_err, evt_rdy, irq, pay_we, pay_last;
    logic [15:0] cmd_word, pay_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    tx_bid_ctrl uut (
        .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .evt_read(evt_read), .rdy_irq_en(rdy_irq_en),
        .free_words(free_words), .rdy_now(rdy_now), .bid_err(bid_err),
        .evt_rdy(evt_rdy), .irq(irq), .cmd_word(cmd_word), .pay_we(pay_we),
        .pay_data(pay_data), .pay_last(pay_last)
    );

    // table: length, expected error, expected word count
    localparam int NV = 7;
    localparam logic [15:0] V_LEN  [NV] = '{16'd1, 16'd1515, 16'd2, 16'd0, 16'd61, 16'hFFFF, 16'd1514};
    localparam bit          V_ERR  [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0};
    localparam int          V_WORDS[NV] = '{1, 0, 1, 0, 31, 0, 757};

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic hw(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic dwr(input logic [15:0] d, output logic we, output logic lst, output logic [15:0] pd);
        @(negedge clk);
        host_we = 1'b1; host_addr = 4'd0; host_wdata = d;
        #1;
        we = pay_we; lst = pay_last; pd = pay_data;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic pulse_evt_read();
        @(negedge clk);
        evt_read = 1'b1;
        @(negedge clk);
        evt_read = 1'b0;
    endtask

    // writes n payload words; returns count of strobes and position of last flag
    task automatic send_words(input int n, output int strobes, output int last_at, output int data_bad);
        logic we, lst;
        logic [15:0] pd;
        strobes = 0; last_at = -1; data_bad = 0;
        for (int i = 0; i < n; i++) begin
            dwr(16'hA500 + 16'(i), we, lst, pd);
            if (we) strobes++;
            if (lst && last_at < 0) last_at = i + 1;
            if (we && pd != 16'hA500 + 16'(i)) data_bad++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int strobes, last_at, bad;
        logic we, lst;
        logic [15:0] pd;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(!rdy_now && !bid_err && !evt_rdy && !irq, "R1 status", int'({rdy_now, bid_err, evt_rdy, irq}), 0);
        check(!pay_we && !pay_last && cmd_word == 16'h0, "R1 outputs", int'(cmd_word), 0);

        // table walk: R2, R3, R6, R10
        free_words = 11'd2047;
        for (int v = 0; v < NV; v++) begin
            hw(4'd6, V_LEN[v]);
            check(bid_err == V_ERR[v], "R2 R10 bid_err", int'(bid_err), int'(V_ERR[v]));
            @(negedge clk);
            check(rdy_now == !V_ERR[v], "R3 R2 ready", int'(rdy_now), int'(!V_ERR[v]));
            if (!V_ERR[v]) begin
                send_words(V_WORDS[v], strobes, last_at, bad);
                check(strobes == V_WORDS[v], "R6 R10 strobes", strobes, V_WORDS[v]);
                check(last_at == V_WORDS[v], "R6 R10 last", last_at, V_WORDS[v]);
                check(bad == 0, "R6 data", bad, 0);
                check(!rdy_now, "R6 ready drops", int'(rdy_now), 0);
            end
        end

        // R3 waiting on space: 10 bytes = 5 words, free one short
        free_words = 11'd4;
        hw(4'd6, 16'd10);
        check(!bid_err, "R3 err cleared", int'(bid_err), 0);
        repeat (3) @(negedge clk);
        check(!rdy_now, "R3 waits for space", int'(rdy_now), 0);
        dwr(16'h1111, we, lst, pd);
        check(!we, "R7 data ignored while waiting", int'(we), 0);
        free_words = 11'd5;
        @(negedge clk);
        check(rdy_now, "R3 ready on space", int'(rdy_now), 1);
        check(evt_rdy && !irq, "R4 evt set irq masked", int'({evt_rdy, irq}), 2);
        rdy_irq_en = 1'b1;
        #1;
        check(irq, "R4 irq enabled", int'(irq), 1);

        // R5 event read
        pulse_evt_read();
        check(!evt_rdy && !irq, "R5 evt cleared", int'({evt_rdy, irq}), 0);
        check(rdy_now, "R5 ready kept", int'(rdy_now), 1);

        // R8 abandon mid-payload
        send_words(2, strobes, last_at, bad);
        check(strobes == 2 && last_at < 0, "R8 partial payload", strobes, 2);
        free_words = 11'd0;
        hw(4'd6, 16'd4);
        check(!rdy_now && !evt_rdy && !bid_err, "R8 abandoned", int'({rdy_now, evt_rdy, bid_err}), 0);
        @(negedge clk);
        check(!rdy_now, "R8 new bid waits", int'(rdy_now), 0);
        free_words = 11'd2047;
        @(negedge clk);
        check(rdy_now && evt_rdy && irq, "R8 R4 new ready", int'({rdy_now, evt_rdy, irq}), 7);
        send_words(2, strobes, last_at, bad);
        check(last_at == 2 && strobes == 2, "R8 count restarts", last_at, 2);
        check(!rdy_now, "R8 done", int'(rdy_now), 0);

        // R7 idle data write
        dwr(16'h2222, we, lst, pd);
        check(!we && !lst, "R7 idle data ignored", int'(we), 0);

        // R9 command latch
        hw(4'd4, 16'h00C9);
        check(cmd_word == 16'h00C9, "R9 cmd", int'(cmd_word), 16'h00C9);
        check(!rdy_now && !bid_err, "R9 no bid effect", int'({rdy_now, bid_err}), 0);

        // R1 reset clears a raised error
        hw(4'd6, 16'd0);
        check(bid_err, "R2 zero length", int'(bid_err), 1);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check(!bid_err && cmd_word == 16'h0, "R1 reset clears", int'(bid_err), 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule